// File: doc/BRIEF.md
# DRAM Bank Command Timing Arbiter

This block sits in one channel of a multi-bank DRAM controller. Each bank presents a pending request: a valid bit, the row it wants, and whether it wants a read or a write. The block keeps an open/closed state and an open row for every bank. It also keeps per-bank countdown timers and two channel-wide timers. From these it works out which banks could legally take an activate, read, write or precharge in the current cycle. It then grants exactly one of them.

The grant decision is combinational from the current requests and the registered timer state. A command granted in cycle t takes effect at the following clock edge. A constraint of T cycles therefore lets the dependent command go in cycle t+T at the earliest, and the block issues it in that very cycle if nothing else competes. Banks are served in rotating order, starting after the bank that was granted last. All timing values are elaboration parameters. Refresh, data-bus occupancy, queuing and address mapping belong to other blocks.

Top module: `dram_cmd_timer`

## Requirements
- R1: After reset no bank is open and `grant` stays low while no request is valid. At most one command is granted per cycle, and only to a bank whose `req_valid` bit is set. The command code on `cmd` is 0 for activate, 1 for read, 2 for write and 3 for precharge.
- R2: An activate goes only to a closed bank. It needs at least T_RP cycles since that bank's last precharge and at least T_RC cycles since its last activate. It opens the row on `cmd_row`, which equals the bank's requested row.
- R3: A read goes only to a bank open on the requested row with `req_wr` low. It needs at least T_RCD cycles since that bank's activate, at least T_CCD cycles since the last read or write on the channel, and at least T_WTR cycles since the last write to any bank.
- R4: A write goes only to a bank open on the requested row with `req_wr` high. It needs at least T_RCDWR cycles since that bank's activate and at least T_CCD cycles since the last read or write on the channel.
- R5: A precharge goes only to an open bank whose open row differs from the requested row. It needs at least T_RAS cycles since that bank's activate and at least T_WTP cycles since that bank's last write. It closes the bank.
- R6: Timers count down by one per cycle and stop at zero. A command with a single eligible bank is issued in the first cycle its constraints allow, with no added cycle.
- R7: When several banks are eligible, the grant goes to the first eligible bank in ascending order (wrapping) after the bank granted last. After reset, the search starts at bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NBANK | Pending request per bank |
| req_row | input | NBANK*ROW_W | Requested row per bank, bank b in bits [b*ROW_W +: ROW_W] |
| req_wr | input | NBANK | 1 = write, 0 = read, per bank |
| grant | output | 1 | A command is issued this cycle |
| cmd | output | 2 | Command code: 0 activate, 1 read, 2 write, 3 precharge |
| cmd_bank | output | clog2(NBANK) | Bank of the issued command |
| cmd_row | output | ROW_W | Requested row of the granted bank |

## Verification
The assertions assume that every timing parameter is at least 1, so that a reload value of T-1 is meaningful. Checks that forbid an adjacent command are only active when the relevant parameter exceeds 1. They also assume requests may change in any cycle, so no property relies on a request staying stable. The stimulus uses small timing values that are all at least 1, with T_WTR, T_WTP and T_CCD above 1. It changes requests only just after a rising edge and otherwise lets rows, directions and valid bits vary freely, which includes row conflicts on every bank.

// File: rtl/dram_cmd_timer.sv
module dram_cmd_timer #(
  parameter int NBANK   = 4,
  parameter int ROW_W   = 4,
  parameter int T_CCD   = 2,
  parameter int T_WTR   = 3,
  parameter int T_WTP   = 4,
  parameter int T_RAS   = 5,
  parameter int T_RC    = 10,
  parameter int T_RP    = 3,
  parameter int T_RCD   = 2,
  parameter int T_RCDWR = 1,
  localparam int BW     = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NBANK-1:0]       req_valid,
  input  logic [NBANK*ROW_W-1:0] req_row,
  input  logic [NBANK-1:0]       req_wr,
  output logic                   grant,
  output logic [1:0]             cmd,
  output logic [BW-1:0]          cmd_bank,
  output logic [ROW_W-1:0]       cmd_row
);
  localparam logic [1:0] C_ACT = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_PRE = 2'd3;

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TMAX = mx(mx(mx(T_CCD, T_WTR), mx(T_WTP, T_RAS)),
                           mx(mx(T_RC, T_RP), mx(T_RCD, T_RCDWR)));
  localparam int CW = (TMAX < 2) ? 1 : $clog2(TMAX);

  function automatic logic [CW-1:0] ld(input int t);
    return (t > 1) ? CW'(t - 1) : '0;
  endfunction

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  logic [NBANK-1:0] open_q;
  logic [ROW_W-1:0] row_q   [NBANK];
  logic [CW-1:0]    rcd_q   [NBANK];
  logic [CW-1:0]    rcdwr_q [NBANK];
  logic [CW-1:0]    ras_q   [NBANK];
  logic [CW-1:0]    rc_q    [NBANK];
  logic [CW-1:0]    rp_q    [NBANK];
  logic [CW-1:0]    wtp_q   [NBANK];
  logic [CW-1:0]    ccd_q, wtr_q;
  logic [BW-1:0]    last_q;

  logic [NBANK-1:0] can_act, can_rd, can_wr, can_pre, elig, hit;
  int               pick;

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      hit[b]     = open_q[b] && (row_q[b] == req_row[b*ROW_W +: ROW_W]);
      can_act[b] = req_valid[b] && !open_q[b] && (rp_q[b] == '0) && (rc_q[b] == '0);
      can_rd[b]  = req_valid[b] && hit[b] && !req_wr[b] && (rcd_q[b] == '0)
                   && (ccd_q == '0) && (wtr_q == '0);
      can_wr[b]  = req_valid[b] && hit[b] && req_wr[b] && (rcdwr_q[b] == '0)
                   && (ccd_q == '0);
      can_pre[b] = req_valid[b] && open_q[b] && !hit[b] && (ras_q[b] == '0)
                   && (wtp_q[b] == '0);
    end
  end

  assign elig = can_act | can_rd | can_wr | can_pre;

  always_comb begin
    grant    = 1'b0;
    cmd_bank = '0;
    pick     = 0;
    for (int i = 1; i <= NBANK; i++) begin
      pick = int'(last_q) + i;
      if (pick >= NBANK) pick = pick - NBANK;
      if (!grant && elig[pick]) begin
        grant    = 1'b1;
        cmd_bank = BW'(pick);
      end
    end
  end

  assign cmd = can_act[cmd_bank] ? C_ACT :
               can_rd[cmd_bank]  ? C_RD  :
               can_wr[cmd_bank]  ? C_WR  : C_PRE;
  assign cmd_row = req_row[int'(cmd_bank)*ROW_W +: ROW_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
      ccd_q  <= '0;
      wtr_q  <= '0;
      last_q <= BW'(NBANK - 1);
      for (int b = 0; b < NBANK; b++) begin
        row_q[b]   <= '0;
        rcd_q[b]   <= '0;
        rcdwr_q[b] <= '0;
        ras_q[b]   <= '0;
        rc_q[b]    <= '0;
        rp_q[b]    <= '0;
        wtp_q[b]   <= '0;
      end
    end else begin
      ccd_q <= dec(ccd_q);
      wtr_q <= dec(wtr_q);
      for (int b = 0; b < NBANK; b++) begin
        rcd_q[b]   <= dec(rcd_q[b]);
        rcdwr_q[b] <= dec(rcdwr_q[b]);
        ras_q[b]   <= dec(ras_q[b]);
        rc_q[b]    <= dec(rc_q[b]);
        rp_q[b]    <= dec(rp_q[b]);
        wtp_q[b]   <= dec(wtp_q[b]);
      end
      if (grant) begin
        last_q <= cmd_bank;
        case (cmd)
          C_ACT: begin
            open_q[cmd_bank]  <= 1'b1;
            row_q[cmd_bank]   <= cmd_row;
            ras_q[cmd_bank]   <= ld(T_RAS);
            rc_q[cmd_bank]    <= ld(T_RC);
            rcd_q[cmd_bank]   <= ld(T_RCD);
            rcdwr_q[cmd_bank] <= ld(T_RCDWR);
          end
          C_RD: ccd_q <= ld(T_CCD);
          C_WR: begin
            ccd_q           <= ld(T_CCD);
            wtr_q           <= ld(T_WTR);
            wtp_q[cmd_bank] <= ld(T_WTP);
          end
          default: begin
            open_q[cmd_bank] <= 1'b0;
            rp_q[cmd_bank]   <= ld(T_RP);
          end
        endcase
      end
    end
  end
endmodule

module dram_cmd_timer_chk #(
  parameter int NBANK = 4,
  parameter int BW    = 2,
  parameter int CW    = 4,
  parameter int T_CCD = 2,
  parameter int T_WTR = 3,
  parameter int T_WTP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBANK-1:0] req_valid,
  input logic             grant,
  input logic [1:0]       cmd,
  input logic [BW-1:0]    cmd_bank,
  input logic [NBANK-1:0] open_q,
  input logic [CW-1:0]    ccd_q,
  input logic [CW-1:0]    wtr_q
);
  localparam logic [CW-1:0] CCD_LD = (T_CCD > 1) ? CW'(T_CCD - 1) : '0;
  localparam logic [CW-1:0] WTR_LD = (T_WTR > 1) ? CW'(T_WTR - 1) : '0;

  a_r1_grant_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> req_valid[cmd_bank]);

  a_r2_act_opens_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && cmd == 2'd0) |=> open_q[$past(cmd_bank)]);

  a_r3_no_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (T_WTR > 1 && grant && cmd == 2'd2) |=> !(grant && cmd == 2'd1));

  a_r4_write_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && cmd == 2'd2) |=> (ccd_q == CCD_LD && wtr_q == WTR_LD));

  a_r5_pre_closes_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && cmd == 2'd3) |=> !open_q[$past(cmd_bank)]);

  a_r5_no_pre_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (T_WTP > 1 && grant && cmd == 2'd2) |=>
      !(grant && cmd == 2'd3 && cmd_bank == $past(cmd_bank)));

  a_r6_wtr_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (wtr_q == '0 && !(grant && cmd == 2'd2)) |=> wtr_q == '0);

  a_r6_ccd_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (ccd_q == '0 && !(grant && cmd[1] != cmd[0])) |=> ccd_q == '0);
endmodule

bind dram_cmd_timer dram_cmd_timer_chk #(
  .NBANK(NBANK), .BW(BW), .CW(CW), .T_CCD(T_CCD), .T_WTR(T_WTR), .T_WTP(T_WTP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .grant(grant), .cmd(cmd),
  .cmd_bank(cmd_bank), .open_q(open_q), .ccd_q(ccd_q), .wtr_q(wtr_q)
);

// File: tb/sim_dram_cmd_timer.sv
`timescale 1ns/1ps
module sim_dram_cmd_timer;
  localparam int NB = 4, RW = 4;
  localparam int CCD = 2, WTR = 3, WTP = 4, RAS = 5, RC = 10, RP = 3, RCD = 2, RCDWR = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NB-1:0] req_valid = '0, req_wr = '0;
  logic [NB*RW-1:0] req_row = '0;
  logic grant;
  logic [1:0] cmd;
  logic [1:0] cmd_bank;
  logic [RW-1:0] cmd_row;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  dram_cmd_timer #(.NBANK(NB), .ROW_W(RW), .T_CCD(CCD), .T_WTR(WTR), .T_WTP(WTP),
    .T_RAS(RAS), .T_RC(RC), .T_RP(RP), .T_RCD(RCD), .T_RCDWR(RCDWR)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row), .req_wr(req_wr),
    .grant(grant), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_row(cmd_row));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference scoreboard
  bit mopen [NB];
  int mrow [NB], la [NB], lp [NB], lw [NB];
  int lcol, lwr, n_rd, n_wr, n_pre, n_act;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        mopen[b] = 0; mrow[b] = 0; la[b] = -1000; lp[b] = -1000; lw[b] = -1000;
      end
      lcol = -1000; lwr = -1000;
    end else if (grant) begin
      int b, r;
      b = int'(cmd_bank);
      r = int'(req_row[b*RW +: RW]);
      chk(req_valid[b], "R1 grant to requesting bank", int'(req_valid[b]), 1);
      case (cmd)
        2'd0: begin
          n_act++;
          chk(!mopen[b], "R2 activate on closed bank", int'(mopen[b]), 0);
          chk(cyc - lp[b] >= RP, "R2 tRP spacing", cyc - lp[b], RP);
          chk(cyc - la[b] >= RC, "R2 tRC spacing", cyc - la[b], RC);
          chk(int'(cmd_row) == r, "R2 activate row", int'(cmd_row), r);
          mopen[b] = 1; mrow[b] = r; la[b] = cyc;
        end
        2'd1: begin
          n_rd++;
          chk(mopen[b] && mrow[b] == r && !req_wr[b], "R3 read on open row", mrow[b], r);
          chk(cyc - la[b] >= RCD, "R3 tRCD spacing", cyc - la[b], RCD);
          chk(cyc - lcol >= CCD, "R3 tCCD spacing", cyc - lcol, CCD);
          chk(cyc - lwr >= WTR, "R3 tWTR spacing", cyc - lwr, WTR);
          lcol = cyc;
        end
        2'd2: begin
          n_wr++;
          chk(mopen[b] && mrow[b] == r && req_wr[b], "R4 write on open row", mrow[b], r);
          chk(cyc - la[b] >= RCDWR, "R4 write-activate spacing", cyc - la[b], RCDWR);
          chk(cyc - lcol >= CCD, "R4 tCCD spacing", cyc - lcol, CCD);
          lcol = cyc; lwr = cyc; lw[b] = cyc;
        end
        default: begin
          n_pre++;
          chk(mopen[b] && mrow[b] != r, "R5 precharge on row conflict", mrow[b], r);
          chk(cyc - la[b] >= RAS, "R5 tRAS spacing", cyc - la[b], RAS);
          chk(cyc - lw[b] >= WTP, "R5 tWTP spacing", cyc - lw[b], WTP);
          mopen[b] = 0; lp[b] = cyc;
        end
      endcase
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic drive0(input int row, input bit wr);
    req_valid = 4'b0001;
    req_row = '0;
    req_row[RW-1:0] = RW'(row);
    req_wr = {3'b000, wr};
  endtask

  task automatic wait_cmd(input logic [1:0] c, input int b, output int t);
    t = -1;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if (grant && cmd == c && int'(cmd_bank) == b) begin
        t = cyc;
        break;
      end
    end
    if (t < 0) chk(0, "R6 command never issued", -1, int'(c));
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int s, t0, t1, t2, t3, t4, t5, t6, t7, t8, t9;
    do_reset();
    repeat (2) @(negedge clk);
    chk(grant == 1'b0, "R1 idle after reset", int'(grant), 0);
    @(posedge clk); #1;

    // single bank exact latencies
    drive0(5, 0);
    s = cyc;
    wait_cmd(2'd0, 0, t0);
    chk(t0 == s, "R2 activate in first cycle", t0 - s, 0);
    wait_cmd(2'd1, 0, t1);
    chk(t1 - t0 == RCD, "R3 read after activate", t1 - t0, RCD);
    wait_cmd(2'd1, 0, t2);
    chk(t2 - t1 == CCD, "R6 read to read", t2 - t1, CCD);
    drive0(5, 1);
    wait_cmd(2'd2, 0, t3);
    chk(t3 - t2 == CCD, "R4 read to write", t3 - t2, CCD);
    drive0(5, 0);
    wait_cmd(2'd1, 0, t4);
    chk(t4 - t3 == WTR, "R3 write to read turnaround", t4 - t3, WTR);
    drive0(5, 1);
    wait_cmd(2'd2, 0, t5);
    drive0(6, 0);
    wait_cmd(2'd3, 0, t6);
    chk(t6 - t5 == WTP, "R5 write to precharge", t6 - t5, WTP);
    wait_cmd(2'd0, 0, t7);
    chk(t7 - t6 == RP, "R2 precharge to activate", t7 - t6, RP);
    chk(int'(cmd_row) == 6, "R2 opened row", int'(cmd_row), 6);
    drive0(7, 0);
    wait_cmd(2'd3, 0, t8);
    chk(t8 - t7 == RAS, "R5 activate to precharge", t8 - t7, RAS);
    wait_cmd(2'd0, 0, t9);
    chk(t9 - t7 == RC, "R2 activate to activate", t9 - t7, RC);

    // rotation order
    do_reset();
    req_wr = '0;
    for (int b = 0; b < NB; b++) req_row[b*RW +: RW] = RW'(b + 1);
    req_valid = '1;
    for (int k = 0; k < NB; k++) begin
      @(negedge clk);
      chk(grant && cmd == 2'd0 && int'(cmd_bank) == k, "R7 round-robin activate order",
          int'(cmd_bank), k);
      @(posedge clk); #1;
    end
    req_valid = '0;
    @(negedge clk);
    chk(grant == 1'b0, "R1 no grant without request", int'(grant), 0);
    @(posedge clk); #1;

    // random traffic with row conflicts
    n_rd = 0; n_wr = 0; n_pre = 0; n_act = 0;
    for (int k = 0; k < 1500; k++) begin
      for (int b = 0; b < NB; b++) begin
        req_valid[b] = ($urandom_range(0, 9) < 7);
        req_wr[b]    = $urandom_range(0, 1);
        req_row[b*RW +: RW] = RW'($urandom_range(0, 2));
      end
      repeat ($urandom_range(1, 6)) @(posedge clk);
      #1;
    end
    req_valid = '0;
    chk(n_rd > 0 && n_wr > 0 && n_pre > 0 && n_act > 0, "R6 all commands seen",
        n_rd * n_wr * n_pre * n_act, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule